// File: doc/BRIEF.md
# MDIO Management Master with Packed Command Word

This block lets software reach the management registers of an Ethernet PHY through the two-wire MDC/MDIO serial interface. Software sees two registers on a simple register bus. The first is a combined command and status word. A single write to it supplies the operation (read or write), the 5-bit PHY address, the 5-bit register address and, for a write, the 16 data bits. That write starts the serial frame at once. The second register holds the port's own PHY address. Software can read and write it directly, and it has no effect on the frame logic.

While a frame is running, software polls the busy flag in the command word. When a read finishes, the read-valid flag is set and the 16 bits that came back from the PHY sit in the data field of the same word. MDC comes from the system clock through a parameterised divider. It runs only while a frame is in progress and stays low otherwise.

Top module: `mdio_master`

## Requirements
- R1: After reset, the command word reads as zero (not busy, read-valid clear, all fields zero), MDC is low, MDIO is not driven (mdio_oe low) and the PHY-address register reads PHY_ADDR_RST.
- R2: The command word (bus_sel = 0) is laid out as follows: bits 15:0 data, bits 20:16 PHY address, bits 25:21 register address, bit 26 operation (1 = read, 0 = write), bit 27 read-valid (read-only), bit 28 busy (read-only), all other bits read as zero. A write to it while idle sets busy from the next cycle. Busy stays set without a break until 2 + 128·DIV_HALF cycles after the accepted write.
- R3: MDC is low while idle. During a frame it is a square wave with DIV_HALF system clocks per half period. Its first rising edge comes DIV_HALF cycles after the frame starts.
- R4: Each frame is 64 MDC periods, sent in this order: 32 ones; start bits 0,1; operation bits 1,0 for a read or 0,1 for a write; the PHY address MSB first; the register address MSB first; a two-bit turnaround; 16 data bits MSB first. On a write the block drives the turnaround as 1,0.
- R5: MDIO changes only when MDC falls, apart from the first preamble bit, which is driven when the frame starts.
- R6: On a write, MDIO is driven for all 64 bits. On a read, MDIO is released from the first turnaround bit to the end of the frame. The block captures data only on the 16 MDC rising edges after the turnaround.
- R7: When a read frame ends, read-valid becomes 1 and the data field holds the 16 captured bits, first captured bit in bit 15. A write frame leaves read-valid at 0.
- R8: A write to the command word while busy is ignored. The fields, the running frame and the flags do not change.
- R9: An accepted command clears read-valid.
- R10: The PHY-address register (bus_sel = 1) holds bits 4:0 of a written word at any time and reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register select: 0 command/status word, 1 PHY-address register |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The bench builds the block with DIV_HALF = 2 and PHY_ADDR_RST = 7. With a two-cycle MDC half period, every frame runs in 258 cycles, so several full reads and writes fit in a short run. Each MDC edge, each turnaround release and the capture phase can then be compared cycle by cycle against the behavioural model. The non-zero reset address makes the reset value of the PHY-address register visible. The phase counter still wraps, so the divider is exercised rather than bypassed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 4 + 2 * ADDR_W + 2 + DATA_W;
  localparam int TA_IDX     = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int DAT_IDX    = TA_IDX + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam int F_DATA  = 0;
  localparam int F_PHY   = F_DATA + DATA_W;
  localparam int F_REG   = F_PHY + ADDR_W;
  localparam int F_OP    = F_REG + ADDR_W;
  localparam int F_VALID = F_OP + 1;
  localparam int F_BUSY  = F_VALID + 1;

  typedef logic [ADDR_W-1:0]     addr_t;
  typedef logic [DATA_W-1:0]     data_t;
  typedef logic [FRAME_BITS-1:0] frame_t;

  function automatic frame_t build_frame(input logic rd, input addr_t phy,
                                         input addr_t rg, input data_t dat);
    logic [1:0] op_bits;
    logic [1:0] ta_bits;
    data_t      payload;
    op_bits = rd ? 2'b10 : 2'b01;
    ta_bits = rd ? 2'b00 : 2'b10;
    payload = rd ? '0 : dat;
    return {{PRE_BITS{1'b1}}, 2'b01, op_bits, phy, rg, ta_bits, payload};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last  = (cnt == LAST);
  assign rise_stb = run && at_last && !mdc;
  assign fall_stb = run && at_last && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  logic   is_read,
  input  frame_t frame,
  input  logic   rise_stb,
  input  logic   fall_stb,
  input  logic   mdio_i,
  output logic   busy,
  output logic   done,
  output logic   mdio_o,
  output logic   mdio_oe,
  output data_t  rdata
);
  localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] REL_IDX     = IDX_W'(TA_IDX - 1);
  localparam logic [IDX_W-1:0] CAPTURE_IDX = IDX_W'(DAT_IDX);

  logic [IDX_W-1:0] idx;
  frame_t           sreg;
  logic             rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      sreg    <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        idx     <= '0;
        sreg    <= frame;
        rd_q    <= is_read;
        mdio_o  <= frame[FRAME_BITS-1];
        mdio_oe <= 1'b1;
        rdata   <= '0;
      end else if (busy) begin
        if (rise_stb && rd_q && idx >= CAPTURE_IDX)
          rdata <= {rdata[DATA_W-2:0], mdio_i};
        if (fall_stb) begin
          if (idx == LAST_IDX) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
          end else begin
            idx     <= idx + 1'b1;
            sreg    <= sreg << 1;
            mdio_o  <= sreg[FRAME_BITS-2];
            mdio_oe <= !(rd_q && idx >= REL_IDX);
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int          DIV_HALF     = 4,
  parameter logic [4:0]  PHY_ADDR_RST = 5'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  data_t  data_q;
  addr_t  phy_q;
  addr_t  reg_q;
  logic   op_q;
  logic   rvalid_q;
  logic   start_q;
  addr_t  own_phy_q;

  logic   seq_busy;
  logic   seq_done;
  data_t  seq_rdata;
  logic   rise_stb;
  logic   fall_stb;
  logic   status_busy;
  logic   cmd_we;
  frame_t frame;

  assign status_busy = start_q | seq_busy | seq_done;
  assign cmd_we      = bus_wr && !bus_sel;
  assign frame       = build_frame(op_q, phy_q, reg_q, data_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q    <= '0;
      phy_q     <= '0;
      reg_q     <= '0;
      op_q      <= 1'b0;
      rvalid_q  <= 1'b0;
      start_q   <= 1'b0;
      own_phy_q <= PHY_ADDR_RST;
    end else begin
      start_q <= 1'b0;
      if (cmd_we && !status_busy) begin
        data_q   <= bus_wdata[F_DATA +: DATA_W];
        phy_q    <= bus_wdata[F_PHY +: ADDR_W];
        reg_q    <= bus_wdata[F_REG +: ADDR_W];
        op_q     <= bus_wdata[F_OP];
        rvalid_q <= 1'b0;
        start_q  <= 1'b1;
      end
      if (seq_done && op_q) begin
        data_q   <= seq_rdata;
        rvalid_q <= 1'b1;
      end
      if (bus_wr && bus_sel)
        own_phy_q <= bus_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      bus_rdata[ADDR_W-1:0] = own_phy_q;
    end else begin
      bus_rdata[F_DATA +: DATA_W] = data_q;
      bus_rdata[F_PHY +: ADDR_W]  = phy_q;
      bus_rdata[F_REG +: ADDR_W]  = reg_q;
      bus_rdata[F_OP]             = op_q;
      bus_rdata[F_VALID]          = rvalid_q;
      bus_rdata[F_BUSY]           = status_busy;
    end
  end

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .run      (seq_busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start_q),
    .is_read  (op_q),
    .frame    (frame),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (seq_busy),
    .done     (seq_done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rdata    (seq_rdata)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst,
  input logic start_q,
  input logic seq_busy,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic rvalid_q,
  input logic op_q
);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    start_q |=> (!start_q && seq_busy));

  p_mdc_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !seq_busy |-> !mdc);

  p_launch_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && $past(seq_busy) && !$fell(mdc)) |-> $stable(mdio_o));

  p_oe_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !seq_busy |-> !mdio_oe);

  p_valid_read_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid_q) |-> op_q);

  p_valid_clear_r9: assert property (@(posedge clk) disable iff (rst)
    start_q |-> !rvalid_q);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_q  (start_q),
  .seq_busy (seq_busy),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .rvalid_q (rvalid_q),
  .op_q     (op_q)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int D          = 2;
  localparam logic [4:0] RST_PHY = 5'd7;
  localparam int END_T      = 2 + 128 * D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // behavioural reference state
  int          m_t = -1;
  logic        m_op = 1'b0;
  logic [4:0]  m_phy = '0, m_reg = '0, m_own = RST_PHY;
  logic [15:0] m_data = '0;
  logic        m_rv = 1'b0;
  logic [15:0] phy_val = '0;
  logic [63:0] m_frame = '0;

  mdio_master #(.DIV_HALF(D), .PHY_ADDR_RST(RST_PHY)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] cmd(input logic rd, input logic [4:0] rg,
                                      input logic [4:0] phy, input logic [15:0] d);
    return {5'b0, rd, rg, phy, d};
  endfunction

  // reference model update at each clock edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_t = -1; m_op = 0; m_phy = 0; m_reg = 0; m_data = 0; m_rv = 0; m_own = RST_PHY;
    end else begin
      if (bus_wr && !bus_sel && m_t < 0) begin
        m_t = 0;
        m_data = bus_wdata[15:0]; m_phy = bus_wdata[20:16];
        m_reg = bus_wdata[25:21]; m_op = bus_wdata[26]; m_rv = 1'b0;
        m_frame = {32'hFFFF_FFFF, 2'b01, m_op ? 2'b10 : 2'b01, m_phy, m_reg,
                   m_op ? 2'b00 : 2'b10, m_op ? 16'h0 : m_data};
      end else if (m_t >= 0) begin
        m_t = m_t + 1;
        if (m_t == END_T) begin
          m_t = -1;
          if (m_op) begin m_rv = 1'b1; m_data = phy_val; end
        end
      end
      if (bus_wr && bus_sel) m_own = bus_wdata[4:0];
    end
  end

  // PHY model and cycle compare, away from the active edge
  always @(negedge clk) begin
    int idx;
    logic e_mdc, e_oe;
    logic [31:0] e_rd;
    if (!rst) begin
      idx = (m_t >= 1) ? (m_t - 1) / (2 * D) : 0;
      e_mdc = (m_t >= 1) ? (((m_t - 1) / D) % 2 == 1) : 1'b0;
      e_oe  = (m_t >= 1 && m_t <= 128 * D) ? (!m_op || idx < 46) : 1'b0;
      e_rd  = bus_sel ? {27'b0, m_own}
                      : {3'b0, (m_t >= 0), m_rv, m_op, m_reg, m_phy, m_data};
      chk("R3 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      chk("R6 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      if (e_oe && m_t >= 1)
        chk("R4/R5 mdio_o", {31'b0, mdio_o}, {31'b0, m_frame[63 - idx]});
      chk("R2/R7/R8/R9/R10 rdata", bus_rdata, e_rd);
      mdio_i <= (m_op && m_t >= 1 && idx >= 48) ? phy_val[63 - idx] : 1'b1;
    end
  end

  task automatic wr(input logic sel, input logic [31:0] w);
    @(posedge clk); #1;
    bus_sel = sel; bus_wr = 1'b1; bus_wdata = w;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_t >= 0) @(posedge clk);
    #1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 60000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd word", bus_rdata, 32'h0);
    chk("R1 mdc", {31'b0, mdc}, 32'h0);
    chk("R1 oe", {31'b0, mdio_oe}, 32'h0);
    @(posedge clk); #1 bus_sel = 1'b1;
    @(negedge clk);
    chk("R1 phy reg", bus_rdata, {27'b0, RST_PHY});
    #1 bus_sel = 1'b0;

    // write frame, with a command sent mid-frame that must be dropped (R8)
    wr(1'b0, cmd(1'b0, 5'h05, 5'h11, 16'hA5C3));
    repeat (40) @(posedge clk);
    wr(1'b0, cmd(1'b1, 5'h1A, 5'h02, 16'h1234));
    @(negedge clk);
    chk("R8 fields kept", bus_rdata & 32'h07FF_FFFF, cmd(1'b0, 5'h05, 5'h11, 16'hA5C3));
    wait_idle();
    chk("R7 write leaves valid clear", {31'b0, bus_rdata[27]}, 32'h0);

    // read frame
    phy_val = 16'h3C5A;
    wr(1'b0, cmd(1'b1, 5'h1E, 5'h1F, 16'h0000));
    wait_idle();
    chk("R7 read valid", {31'b0, bus_rdata[27]}, 32'h1);
    chk("R7 read data", {16'b0, bus_rdata[15:0]}, 32'h3C5A);

    // new command clears read-valid (R9)
    wr(1'b0, cmd(1'b0, 5'h00, 5'h00, 16'h8001));
    @(negedge clk);
    chk("R9 valid cleared", {31'b0, bus_rdata[27]}, 32'h0);
    chk("R2 busy set", {31'b0, bus_rdata[28]}, 32'h1);
    wait_idle();

    // reads with edge data patterns
    phy_val = 16'hFFFF;
    wr(1'b0, cmd(1'b1, 5'h00, 5'h00, 16'hFFFF));
    wait_idle();
    chk("R7 all ones", {16'b0, bus_rdata[15:0]}, 32'hFFFF);
    phy_val = 16'h0001;
    wr(1'b0, cmd(1'b1, 5'h15, 5'h0A, 16'h0));
    wait_idle();
    chk("R7 lsb only", {16'b0, bus_rdata[15:0]}, 32'h0001);

    // own PHY address register (R10)
    wr(1'b1, 32'hFFFF_FFFB);
    @(posedge clk); #1 bus_sel = 1'b1;
    @(negedge clk);
    chk("R10 phy reg", bus_rdata, 32'h0000_001B);
    #1 bus_sel = 1'b0;
    repeat (3) @(posedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule